// File: doc/BRIEF.md
# YCbCr 4:2:2 Byte-to-Pixel Deinterleaver

This block sits behind a video decoder whose output is an 8-bit parallel bus. On that bus the 4:2:2 samples arrive interleaved as Cb, Y, Cr, Y, … on a byte clock that runs at twice the pixel rate, for example 27 MHz for a 13.5 MHz pixel rate. The block regroups each chroma/luma byte pair into one 16-bit pixel word. A one-cycle strobe marks every finished word, and the downstream video-to-stream bridge uses that strobe as its clock enable. Words therefore come out at most once every two byte clocks.

The decoder's active-video signal sets the byte phase. While it is low, the phase machine rests in `ST_IDLE`. The first byte seen with active-video high is taken as Cb, and the machine moves to `ST_WANT_Y`. The luma byte that follows completes a word, and the machine goes to `ST_WANT_C`. From there the next active byte is chroma again and leads back to `ST_WANT_Y`. Active-video going low sends the machine from any state back to `ST_IDLE`. If that happens in `ST_WANT_Y`, the chroma byte held so far is dropped.

Vertical sync, field identifier and active-video are carried through the same delay as the pixel words. A frame-building stage downstream therefore sees them aligned with the data.

Top module: `ycc422_byte_deinterleaver`

## Requirements
- R1: A synchronous active-high reset clears every output to zero and keeps `pix_stb` low while reset is held.
- R2: When `pix_stb` is high, `pix_word[15:8]` holds the chroma byte of the pair and `pix_word[7:0]` holds the luma byte that followed it.
- R3: `pix_stb` is never high on two consecutive clock cycles.
- R4: The first word of every active line is Cb, shown as `pix_cr_sel` = 0.
- R5: Within one line, `pix_cr_sel` alternates on successive words: 0 for Cb and 1 for Cr.
- R6: `pix_stb` is never high unless `pix_active` is high.
- R7: If active-video falls after an odd number of bytes, the unpaired chroma byte produces no word, and the next line starts again at Cb.
- R8: A word appears on the outputs, with its strobe, two clock edges after the edge that samples its luma byte.
- R9: `pix_vsync`, `pix_field` and `pix_active` follow `vid_vsync`, `vid_field` and `vid_active` with the same two-edge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_byte | input | 8 | Interleaved Cb/Y/Cr/Y byte stream |
| vid_active | input | 1 | High while the line carries active samples |
| vid_vsync | input | 1 | Vertical sync from the decoder |
| vid_field | input | 1 | Field identifier from the decoder |
| pix_word | output | 16 | Chroma in bits 15:8, luma in bits 7:0 |
| pix_stb | output | 1 | One-cycle qualifier and clock enable for each word |
| pix_cr_sel | output | 1 | 0 if the word's chroma is Cb, 1 if it is Cr |
| pix_active | output | 1 | Active-video, delayed to match the words |
| pix_vsync | output | 1 | Vertical sync, delayed to match the words |
| pix_field | output | 1 | Field identifier, delayed to match the words |

## Verification
The hardest case to reach is a line that ends in `ST_WANT_Y`. In that case a chroma byte is waiting, and active-video is cut one byte short. The bench drives lines of odd length, including a line of a single byte. It restarts active-video after only one idle cycle, so any chroma that was kept stale or any Cb/Cr toggle that was not reset would show in the very next word. A behavioural model counts bytes since the last rising edge of active-video and predicts every output on every cycle.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WANT_C = 2'd1,
        ST_WANT_Y = 2'd2
    } phase_e;
endpackage

// File: rtl/ccp_phase_fsm.sv
module ccp_phase_fsm
    import ccp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    output logic take_c,
    output logic take_y,
    output logic csel_o
);
    phase_e state_q, state_d;
    logic   csel_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d = state_q;
        take_c  = 1'b0;
        take_y  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (act_i) begin
                    take_c  = 1'b1;
                    state_d = ST_WANT_Y;
                end
            end
            ST_WANT_C: begin
                if (act_i) begin
                    take_c  = 1'b1;
                    state_d = ST_WANT_Y;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WANT_Y: begin
                if (act_i) begin
                    take_y  = 1'b1;
                    state_d = ST_WANT_C;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Cb/Cr toggle: cleared outside active video, flips per finished pair
    always_ff @(posedge clk) begin
        if (rst || !act_i) csel_q <= 1'b0;
        else if (take_y)   csel_q <= ~csel_q;
    end

    assign csel_o = csel_q;

    // R4: a line always begins in idle with the toggle on Cb
    a_r4_line_starts_cb: assert property (@(posedge clk) disable iff (rst)
        $rose(act_i) |-> (state_q == ST_IDLE && csel_q == 1'b0));

    // R5: each completed pair flips the chroma select
    a_r5_sel_toggles: assert property (@(posedge clk) disable iff (rst)
        (take_y && act_i) |=> (csel_q != $past(csel_q)));

    // R7: losing active video with a half pair returns to idle
    a_r7_odd_discard: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WANT_Y && !act_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/ccp_word_asm.sv
module ccp_word_asm #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BYTE_W-1:0]     byte_i,
    input  logic                  take_c,
    input  logic                  take_y,
    input  logic                  csel_i,
    output logic [2*BYTE_W-1:0]   word_o,
    output logic                  stb_o,
    output logic                  sel_o
);
    logic [BYTE_W-1:0] chroma_hold;
    logic [BYTE_W-1:0] pair_c, pair_y;
    logic              pair_vld, pair_sel;

    // stage 1: hold chroma, capture the finished pair
    always_ff @(posedge clk) begin
        if (rst) begin
            chroma_hold <= '0;
            pair_c      <= '0;
            pair_y      <= '0;
            pair_vld    <= 1'b0;
            pair_sel    <= 1'b0;
        end else begin
            pair_vld <= take_y;
            if (take_c) chroma_hold <= byte_i;
            if (take_y) begin
                pair_c   <= chroma_hold;
                pair_y   <= byte_i;
                pair_sel <= csel_i;
            end
        end
    end

    // stage 2: output register, loaded only with a valid pair
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            stb_o  <= 1'b0;
            sel_o  <= 1'b0;
        end else begin
            stb_o <= pair_vld;
            if (pair_vld) begin
                word_o <= {pair_c, pair_y};
                sel_o  <= pair_sel;
            end
        end
    end

    // R2: the luma half of the word is the byte captured at the pair edge
    a_r2_luma_low_half: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> (stb_o && word_o[BYTE_W-1:0] == $past(pair_y)
                      && word_o[2*BYTE_W-1:BYTE_W] == $past(pair_c)));
endmodule

// File: rtl/ccp_delay_line.sv
module ccp_delay_line #(
    parameter int WIDTH = 3,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stg[g] <= '0;
                else if (g == 0) stg[g] <= d_i;
                else             stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/ycc422_byte_deinterleaver.sv
module ycc422_byte_deinterleaver #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BYTE_W-1:0]   vid_byte,
    input  logic                vid_active,
    input  logic                vid_vsync,
    input  logic                vid_field,
    output logic [2*BYTE_W-1:0] pix_word,
    output logic                pix_stb,
    output logic                pix_cr_sel,
    output logic                pix_active,
    output logic                pix_vsync,
    output logic                pix_field
);
    localparam int PIPE_LAT = 2;
    localparam int SIDE_W   = 3;

    logic take_c, take_y, csel;
    logic [SIDE_W-1:0] side_q;

    ccp_phase_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .act_i  (vid_active),
        .take_c (take_c),
        .take_y (take_y),
        .csel_o (csel)
    );

    ccp_word_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk    (clk),
        .rst    (rst),
        .byte_i (vid_byte),
        .take_c (take_c),
        .take_y (take_y),
        .csel_i (csel),
        .word_o (pix_word),
        .stb_o  (pix_stb),
        .sel_o  (pix_cr_sel)
    );

    ccp_delay_line #(.WIDTH(SIDE_W), .DEPTH(PIPE_LAT)) u_side (
        .clk (clk),
        .rst (rst),
        .d_i ({vid_active, vid_vsync, vid_field}),
        .q_o (side_q)
    );

    assign {pix_active, pix_vsync, pix_field} = side_q;

    // R3: words come at most every second byte clock
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        pix_stb |=> !pix_stb);

    // R6: a strobe only inside the delayed active window
    a_r6_stb_in_active: assert property (@(posedge clk) disable iff (rst)
        pix_stb |-> pix_active);
endmodule

// File: tb/ycc422_byte_deinterleaver_tb_top.sv
module ycc422_byte_deinterleaver_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  vid_byte = '0;
    logic        vid_active = 1'b0, vid_vsync = 1'b0, vid_field = 1'b0;
    logic [15:0] pix_word;
    logic        pix_stb, pix_cr_sel, pix_active, pix_vsync, pix_field;

    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    ycc422_byte_deinterleaver dut_i (
        .clk(clk), .rst(rst), .vid_byte(vid_byte), .vid_active(vid_active),
        .vid_vsync(vid_vsync), .vid_field(vid_field), .pix_word(pix_word),
        .pix_stb(pix_stb), .pix_cr_sel(pix_cr_sel), .pix_active(pix_active),
        .pix_vsync(pix_vsync), .pix_field(pix_field)
    );

    typedef struct {
        logic        stb;
        logic [15:0] w;
        logic        sel;
        logic        act, vs, fid;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    exp_t zero_e = '{stb:1'b0, w:16'h0, sel:1'b0, act:1'b0, vs:1'b0, fid:1'b0};
    int   idx = 0;
    logic [7:0] held = '0;
    logic       in_reset_view = 1'b1;

    initial begin
        exp_q.push_back(zero_e);
        cur = zero_e;
    end

    // behavioural model: entry pushed at an edge appears on the outputs one edge later
    always @(posedge clk) begin
        exp_t e;
        cur = exp_q.pop_front();
        in_reset_view = rst;
        e = zero_e;
        if (!rst) begin
            e.act = vid_active; e.vs = vid_vsync; e.fid = vid_field;
            if (vid_active) begin
                if (idx % 2 == 0) held = vid_byte;
                else begin
                    e.stb = 1'b1;
                    e.w   = {held, vid_byte};
                    e.sel = ((idx / 2) % 2) == 1;
                end
                idx++;
            end else idx = 0;
        end else idx = 0;
        exp_q.push_back(e);
    end

    task automatic chk(input string tag, input logic [15:0] act_v, input logic [15:0] exp_v);
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act_v, exp_v);
        end
    endtask

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        if (in_reset_view) begin
            chk("R1 reset stb", {15'h0, pix_stb}, 16'h0);
            chk("R1 reset word", pix_word, 16'h0);
            chk("R1 reset side", {13'h0, pix_active, pix_vsync, pix_field}, 16'h0);
        end else begin
            chk("R3/R6/R8 strobe", {15'h0, pix_stb}, {15'h0, cur.stb});
            chk("R9 side signals", {13'h0, pix_active, pix_vsync, pix_field},
                {13'h0, cur.act, cur.vs, cur.fid});
            if (cur.stb) begin
                chk("R2/R7/R8 word", pix_word, cur.w);
                chk("R4/R5 cr_sel", {15'h0, pix_cr_sel}, {15'h0, cur.sel});
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vid_active = 1'b0;
            vid_byte   = 8'($urandom);
        end
    endtask

    task automatic line(input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            vid_active = 1'b1;
            vid_byte   = 8'($urandom);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                idle(3);
                vid_vsync = 1'b1; idle(2); vid_field = 1'b1; idle(2); vid_vsync = 1'b0;
                line(8);  idle(4);            // R4 R5 even line
                line(7);  idle(1);            // R7 odd line, quick restart
                line(6);  idle(1);
                line(1);  idle(1);            // R7 single chroma byte dropped
                line(2);  idle(2);
                vid_field = 1'b0;
                line(3);  idle(1);
                line(12); idle(3);
                for (int k = 0; k < 20; k++) begin
                    vid_vsync = k[0];
                    vid_field = k[1];
                    line(1 + ($urandom % 9));
                    idle(1 + ($urandom % 3));
                end
                @(negedge clk); rst = 1'b1;   // R1 reset after traffic
                @(negedge clk); vid_active = 1'b1;
                @(negedge clk); @(negedge clk);
                rst = 1'b0; vid_active = 1'b0;
                idle(2);
                line(4);  idle(4);
            end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule